// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when an SDRAM controller must spend a command slot on an auto-refresh. A free-running counter marks the end of each average refresh interval (1300 clocks at a 6 ns clock by default). Each interval end adds one unit to a refresh debt, and each issued refresh pays one unit back. While the debt is nonzero the block asks the command scheduler for a slot. The scheduler may postpone that slot while other traffic is pending, up to a limit of eight owed refreshes. At the limit the block raises an urgent flag. The scheduler must then close every bank and hand the slot over ahead of all other traffic.

A grant from the scheduler commits the block to one refresh. It then waits until the bank-idle inputs show every bank precharged, and drives the auto-refresh strobe for a single cycle. After that it holds a command-block output high so that nothing else is sent before the refresh cycle time has passed (12 clocks by default). Self-refresh timing and data handling are handled elsewhere in the controller.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `refReq`, `refUrgent`, `refCmd` and `cmdBlock` are all low. The debt is zero and the interval count starts from zero at release.
- R2: The debt rises by one on the INTERVAL-th clock edge after reset release and on every INTERVAL-th edge after that. `refReq` is high exactly when the debt is nonzero.
- R3: The debt never exceeds DEBT_MAX. An interval end while the debt is at DEBT_MAX is dropped. `refUrgent` is high exactly when the debt equals DEBT_MAX.
- R4: A grant that arrives while the debt is zero has no effect: no refresh strobe and no command block follow.
- R5: A grant sampled while the block is idle and owes a refresh commits it to exactly one refresh, even if the grant is then removed. `refCmd` is high only in a cycle in which all NUM_BANKS bits of `bankIdle` are 1. The strobe appears in the first such cycle after the commit edge, and it lasts one cycle.
- R6: Each `refCmd` lowers the debt by one at the following edge. If an interval end falls on that same edge, the debt is unchanged.
- R7: After a `refCmd` cycle, `cmdBlock` is high for exactly TRFC-1 cycles. Grants are ignored during that time. No two refresh strobes are closer than TRFC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bankIdle | input | NUM_BANKS | One bit per bank, 1 when that bank is precharged |
| refGrant | input | 1 | Slot grant from the command scheduler |
| refReq | output | 1 | At least one refresh is owed |
| refUrgent | output | 1 | The debt has reached DEBT_MAX |
| refCmd | output | 1 | One-cycle auto-refresh command strobe |
| cmdBlock | output | 1 | Other commands are held off during the refresh cycle time |

## Verification
The debt registers change on the edge that ends an interval. `refReq` and `refUrgent` therefore move on that exact edge, counted from reset release. A grant is sampled on one edge, and `refCmd` is high in the following cycle if the banks are already idle. If they are not, the strobe appears in the same cycle that `bankIdle` goes all-ones. `cmdBlock` then covers the next TRFC-1 cycles. The bench runs a small configuration, places every stimulus at a known edge number, and predicts each strobe edge in a scoreboard queue. Level outputs are sampled one nanosecond after the edge on which the requirements say they change.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_BUSY = 2'd2
  } drsState_e;

  typedef struct packed {
    logic issue;    // refresh sent this cycle: pay one unit of debt, load the busy timer
    logic busyRun;  // count the busy timer down
  } drsStrobe_t;
endpackage

// File: rtl/dram_refresh_datapath.sv
module dram_refresh_datapath
  import drs_pkg::*;
#(
  parameter int INTERVAL = 1300,
  parameter int DEBT_MAX = 8,
  parameter int TRFC     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  drsStrobe_t strobe,
  output logic       debtNz,
  output logic       debtFull,
  output logic       busyDone
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int BW = (TRFC > 2) ? $clog2(TRFC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(INTERVAL - 1);
  localparam logic [DW-1:0] DEBT_TOP  = DW'(DEBT_MAX);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(TRFC - 2);

  logic [TW-1:0] tickCnt;
  logic [DW-1:0] debt;
  logic [BW-1:0] busyCnt;
  logic          tick;
  logic          incr;

  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // An interval end is dropped when the debt is full, unless a refresh pays one back on the same edge.
  assign incr = tick && ((debt != DEBT_TOP) || strobe.issue);

  always_ff @(posedge clk) begin
    if (!rst_n) debt <= '0;
    else begin
      case ({incr, strobe.issue})
        2'b10:   debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            busyCnt <= '0;
    else if (strobe.issue)                 busyCnt <= BUSY_LOAD;
    else if (strobe.busyRun && busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  assign debtNz   = (debt != '0);
  assign debtFull = (debt == DEBT_TOP);
  assign busyDone = (busyCnt == '0);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refGrant,
  input  logic       allIdle,
  input  logic       debtNz,
  input  logic       busyDone,
  output drsStrobe_t strobe,
  output logic       refCmd,
  output logic       cmdBlock
);
  drsState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    refCmd    = 1'b0;
    case (state)
      ST_IDLE: if (refGrant && debtNz) nextState = ST_PREP;
      ST_PREP: if (allIdle) begin
        refCmd       = 1'b1;
        strobe.issue = 1'b1;
        nextState    = ST_BUSY;
      end
      ST_BUSY: begin
        strobe.busyRun = 1'b1;
        if (busyDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cmdBlock = (state == ST_BUSY);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int INTERVAL  = 1300,
  parameter int DEBT_MAX  = 8,
  parameter int TRFC      = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 refGrant,
  output logic                 refReq,
  output logic                 refUrgent,
  output logic                 refCmd,
  output logic                 cmdBlock
);
  drsStrobe_t strobe;
  logic debtNz, debtFull, busyDone;

  dram_refresh_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .refGrant (refGrant),
    .allIdle  (&bankIdle),
    .debtNz   (debtNz),
    .busyDone (busyDone),
    .strobe   (strobe),
    .refCmd   (refCmd),
    .cmdBlock (cmdBlock)
  );

  dram_refresh_datapath #(
    .INTERVAL (INTERVAL),
    .DEBT_MAX (DEBT_MAX),
    .TRFC     (TRFC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .debtNz   (debtNz),
    .debtFull (debtFull),
    .busyDone (busyDone)
  );

  assign refReq    = debtNz;
  assign refUrgent = debtFull;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int TRFC      = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bankIdle,
  input logic                 refGrant,
  input logic                 refReq,
  input logic                 refUrgent,
  input logic                 refCmd,
  input logic                 cmdBlock
);
  localparam int SW = $clog2(TRFC + 1);
  localparam logic [SW-1:0] GAP = SW'(TRFC);

  logic [SW-1:0] sinceCmd;

  always_ff @(posedge clk) begin
    if (!rst_n)             sinceCmd <= GAP;
    else if (refCmd)        sinceCmd <= SW'(1);
    else if (sinceCmd < GAP) sinceCmd <= sinceCmd + 1'b1;
  end

  a_r5_cmd_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |-> (&bankIdle));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |=> !refCmd);
  a_r4_cmd_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |-> refReq);
  a_r3_urgent_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
    refUrgent |-> refReq);
  a_r7_block_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |=> cmdBlock);
  a_r7_no_cmd_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmdBlock |-> !refCmd);
  a_r7_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |-> (sinceCmd >= GAP));
  a_r7_grant_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdBlock && refGrant) |=> !refCmd);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .TRFC      (TRFC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bankIdle  (bankIdle),
  .refGrant  (refGrant),
  .refReq    (refReq),
  .refUrgent (refUrgent),
  .refCmd    (refCmd),
  .cmdBlock  (cmdBlock)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int NB = 4;
  localparam int IV = 16;
  localparam int DM = 3;
  localparam int TR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] bankIdle = '1;
  logic          refGrant = 1'b1;
  logic          refReq, refUrgent, refCmd, cmdBlock;

  int  edges = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  int  expQ[$];

  dram_refresh_sched #(.NUM_BANKS(NB), .INTERVAL(IV), .DEBT_MAX(DM), .TRFC(TR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bankIdle(bankIdle), .refGrant(refGrant),
    .refReq(refReq), .refUrgent(refUrgent), .refCmd(refCmd), .cmdBlock(cmdBlock)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, edges, act, exp);
    end
  endtask

  task automatic atEdge(int k);
    while (edges < k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expectCmd(int e);
    expQ.push_back(e);
  endtask

  // Monitor: compare every refresh strobe against the predicted edge
  always @(negedge clk) begin
    if (rst_n && refCmd) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R5 unexpected refCmd after edge %0d: actual 1 expected 0", edges);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != edges) begin
          nFails++;
          $display("FAIL R5 refCmd edge: actual %0d expected %0d", edges, e);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #20000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: all outputs low while reset is held
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "refReq in reset", refReq, 1'b0);
    chk("R1", "refUrgent in reset", refUrgent, 1'b0);
    chk("R1", "refCmd in reset", refCmd, 1'b0);
    chk("R1", "cmdBlock in reset", cmdBlock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: the grant is held while the debt is zero
    for (int k = 1; k <= 6; k++) begin
      atEdge(k);
      chk("R4", "refCmd with zero debt", refCmd, 1'b0);
      chk("R4", "cmdBlock with zero debt", cmdBlock, 1'b0);
    end
    refGrant = 1'b0;

    // R2: first interval end on edge IV
    atEdge(IV - 1);
    chk("R2", "refReq before first interval", refReq, 1'b0);
    atEdge(IV);
    chk("R2", "refReq after first interval", refReq, 1'b1);

    // R5: commit while banks are busy, strobe held until all banks idle
    atEdge(20);
    refGrant = 1'b1;
    bankIdle = 4'b1011;
    atEdge(21);
    refGrant = 1'b0;
    chk("R5", "refCmd with bank open", refCmd, 1'b0);
    atEdge(23);
    chk("R5", "refCmd with bank open", refCmd, 1'b0);
    atEdge(24);
    expectCmd(24);
    bankIdle = '1;
    atEdge(25);
    chk("R6", "refReq after paying debt", refReq, 1'b0);
    chk("R7", "cmdBlock first busy cycle", cmdBlock, 1'b1);
    atEdge(28);
    chk("R7", "cmdBlock last busy cycle", cmdBlock, 1'b1);
    atEdge(29);
    chk("R7", "cmdBlock after TRFC-1 cycles", cmdBlock, 1'b0);

    // R3: debt climbs to the limit and saturates
    atEdge(63);
    chk("R3", "refUrgent below limit", refUrgent, 1'b0);
    atEdge(64);
    chk("R3", "refUrgent at limit", refUrgent, 1'b1);
    atEdge(80);
    chk("R3", "refUrgent after dropped interval", refUrgent, 1'b1);

    // R7: a grant held through three refreshes; R3 saturation seen as debt 3 not 4
    atEdge(81);
    refGrant = 1'b1;
    expectCmd(82);
    expectCmd(88);
    expectCmd(94);
    atEdge(83);
    chk("R3", "refUrgent after one refresh", refUrgent, 1'b0);
    atEdge(85);
    chk("R7", "refCmd during block with grant", refCmd, 1'b0);
    chk("R7", "cmdBlock with grant held", cmdBlock, 1'b1);
    atEdge(94);
    refGrant = 1'b0;
    atEdge(95);
    chk("R3", "refReq after three refreshes", refReq, 1'b0);
    atEdge(96);
    chk("R2", "refReq after interval", refReq, 1'b1);

    // R6: refresh and interval end on the same edge
    atEdge(110);
    refGrant = 1'b1;
    expectCmd(111);
    atEdge(111);
    refGrant = 1'b0;
    atEdge(112);
    chk("R6", "refReq after tick and refresh together", refReq, 1'b1);
    atEdge(127);
    chk("R6", "refReq before next interval", refReq, 1'b1);
    chk("R3", "refUrgent with debt one", refUrgent, 1'b0);
    atEdge(135);

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R5 missing refCmd: actual %0d pending expected 0", expQ.size());
    end
    finish_run();
  end
endmodule